// File: doc/BRIEF.md
# Serial-Readout SAR ADC Sequencer

This block is the digital controller of a slow 8-bit successive-approximation converter used for housekeeping measurements such as supply level or temperature. It sleeps in a power-down state until a rising edge on its enable input. After that edge it waits a fixed wake-up time. It then runs a binary search, presenting trial codes to an external DAC and reading back a comparator. Finally it shifts the result out on a bit clock and a data line that it generates itself.

The serial output is a push-only stream with no valid/ready pairing. The block owns the bit clock and has no way to be stalled. The receiver must capture each bit on the rising edge of the bit clock; there is no back-pressure and no retransmission. All timing counts cycles of a single reference clock. The default parameters assume a 4.92 MHz reference, which gives a 2.44 µs bit period and about 20 µs from enable to the first bit-clock edge.

Top module: `sar_readout_seq`

## Requirements
- R1: While idle (after reset and between conversions), `sclk_o` and `sdata_o` are low and `trial_code` is 0.
- R2: A conversion starts only when `conv_en` is sampled high on a clock edge after having been sampled low on the previous edge. After reset, the previous sample counts as high, so an enable held high through reset release does not start a conversion.
- R3: A rising edge of `conv_en` during a conversion is ignored. If `conv_en` stays high after a conversion ends, no new conversion starts until `conv_en` has been sampled low again.
- R4: The search sets the trial bits one at a time, from the most significant bit to the least. Each trial bit is kept if `cmp_ge` is 1, which means the input is at or above the level of the current `trial_code`. The result is the largest code whose level does not exceed the input.
- R5: The result goes out as `W` bits, most significant bit first, one bit per bit-clock period. `sdata_o` changes only while `sclk_o` is low: on the edge where `sclk_o` falls, or when the first bit is loaded. `sdata_o` is stable while `sclk_o` is high.
- R6: Counted in clock edges from the start edge, `sclk_o` first rises at edge `WAKE_CYC`. Each high phase and each low phase lasts `HALF` cycles. `sclk_o` falls for the last time, with `sdata_o` going low on the same edge, at edge `WAKE_CYC + (2*W-1)*HALF`. With the default parameters that is edge 188, inside a budget of 196 cycles (40 µs).
- R7: The result saturates. If the comparator always reports 1, the result is all ones. If it always reports 0, the result is all zeros.
- R8: A low `rst_n` on a clock edge, even in the middle of a conversion, returns the block to idle at that edge: `sclk_o`, `sdata_o` and `trial_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_en | input | 1 | Conversion enable; a rising edge starts a conversion |
| cmp_ge | input | 1 | Comparator: 1 when the input is at or above the `trial_code` level |
| trial_code | output | W | Trial code for the external DAC during the search; 0 otherwise |
| sclk_o | output | 1 | Generated serial bit clock |
| sdata_o | output | 1 | Serial result data, valid at each rising edge of `sclk_o` |

## Verification
The bench builds the block with its default parameters: 8 bits, a half-period of 6 cycles and a wake-up time of 98 cycles. At these values the real 40 µs budget is live, since the last falling edge comes at cycle 188 against a limit of 196. The comparator is modelled from a millivolt stimulus over the 0.5 V to 2.5 V span. This lets the full waveform be checked edge by edge against closed-form positions for mid-scale, arbitrary, saturating-high and saturating-low inputs. The same defaults make the retrigger window, held enable and mid-conversion reset reachable within a few hundred cycles each.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SEARCH,
    ST_SHIFT
  } seq_state_t;
endpackage

// File: rtl/sar_start_gate.sv
// Detects a fresh low-to-high transition of the enable input and turns it
// into a start pulse only while the sequencer is idle.
module sar_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic idle_i,
  output logic start_o
);
  logic en_q;

  // Reset value 1: enable must be observed low before any start.
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_i;
  end

  assign start_o = idle_i & en_i & ~en_q;
endmodule

// File: rtl/sar_core.sv
// Binary search register: a one-hot mask walks from MSB to LSB.
module sar_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         decide_i,
  input  logic         cmp_ge_i,
  output logic [W-1:0] trial_o
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] trial_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] kept;

  assign kept = cmp_ge_i ? trial_q : (trial_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (load_i) begin
      trial_q <= TOP_BIT;
      mask_q  <= TOP_BIT;
    end else if (decide_i && (mask_q != '0)) begin
      trial_q <= kept | (mask_q >> 1);
      mask_q  <= mask_q >> 1;
    end
  end

  assign trial_o = trial_q;
endmodule

// File: rtl/sar_ser_tx.sv
// Self-clocked serializer: low half then high half per bit, MSB first.
module sar_ser_tx #(
  parameter int W    = 8,
  parameter int HALF = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] word_i,
  output logic         sclk_o,
  output logic         sdata_o,
  output logic         done_o
);
  localparam int HW = $clog2(HALF + 1);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [HW-1:0] H_LAST = HW'(HALF - 1);
  localparam logic [BW-1:0] B_LAST = BW'(W - 1);

  logic [W-1:0]  shreg;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bitn;
  logic          active;
  logic          sclk_q;
  logic          sdata_q;
  logic          half_end;

  assign half_end = active && (hcnt == H_LAST);
  assign done_o   = half_end && sclk_q && (bitn == B_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      hcnt    <= '0;
      bitn    <= '0;
      active  <= 1'b0;
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
    end else if (go_i) begin
      shreg   <= word_i;
      sdata_q <= word_i[W-1];
      hcnt    <= '0;
      bitn    <= '0;
      sclk_q  <= 1'b0;
      active  <= 1'b1;
    end else if (half_end) begin
      hcnt <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        sclk_q <= 1'b0;
        if (bitn == B_LAST) begin
          active  <= 1'b0;
          sdata_q <= 1'b0;
        end else begin
          bitn    <= bitn + 1'b1;
          shreg   <= shreg << 1;
          sdata_q <= shreg[W-2];
        end
      end
    end else if (active) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign sclk_o  = sclk_q;
  assign sdata_o = sdata_q;
endmodule

// File: rtl/sar_readout_seq.sv
// Top: wake-up wait, SAR search, then serial readout of the result.
module sar_readout_seq
  import sar_seq_pkg::*;
#(
  parameter int W        = 8,
  parameter int HALF     = 6,
  parameter int WAKE_CYC = 98
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_en,
  input  logic         cmp_ge,
  output logic [W-1:0] trial_code,
  output logic         sclk_o,
  output logic         sdata_o
);
  // Search takes 2*W+1 cycles (settle, decide per bit, then hand-off);
  // the serializer spends HALF low cycles before its first rising edge.
  localparam int SRCH_LEN = 2 * W + 1;
  localparam int WAKE_LEN = WAKE_CYC - HALF - SRCH_LEN;
  localparam int CNT_MAX  = (WAKE_LEN > SRCH_LEN) ? WAKE_LEN : SRCH_LEN;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_LEN - 1);
  localparam logic [CW-1:0] SRCH_LAST = CW'(SRCH_LEN - 1);

  seq_state_t st;
  logic [CW-1:0] cnt;
  logic busy;
  logic start;
  logic sar_load;
  logic sar_decide;
  logic ser_go;
  logic ser_done;

  assign busy = (st != ST_IDLE);

  sar_start_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (conv_en),
    .idle_i  (~busy),
    .start_o (start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st  <= ST_WAKE;
            cnt <= '0;
          end
        end
        ST_WAKE: begin
          if (cnt == WAKE_LAST) begin
            st  <= ST_SEARCH;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SEARCH: begin
          if (cnt == SRCH_LAST) begin
            st  <= ST_SHIFT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (ser_done) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sar_load   = (st == ST_WAKE) && (cnt == WAKE_LAST);
  assign sar_decide = (st == ST_SEARCH) && cnt[0];
  assign ser_go     = (st == ST_SEARCH) && (cnt == SRCH_LAST);

  sar_core #(.W(W)) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (ser_done),
    .load_i   (sar_load),
    .decide_i (sar_decide),
    .cmp_ge_i (cmp_ge),
    .trial_o  (trial_code)
  );

  sar_ser_tx #(.W(W), .HALF(HALF)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (ser_go),
    .word_i  (trial_code),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .done_o  (ser_done)
  );
endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
  parameter int W    = 8,
  parameter int HALF = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sclk_o,
  input logic         sdata_o,
  input logic [W-1:0] trial_code,
  input logic         busy,
  input logic         start
);
  localparam int RW = $clog2(HALF + 2);
  logic [RW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)      hi_run <= '0;
    else if (sclk_o) hi_run <= hi_run + 1'b1;
    else             hi_run <= '0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk_o && !sdata_o && trial_code == '0));

  assert_start_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  assert_start_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  assert_bit_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  assert_data_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> !sclk_o);

  assert_high_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_o) && $past(rst_n)) |-> (hi_run == RW'(HALF)));

  assert_reset_clears_R8: assert property (@(posedge clk)
    !rst_n |=> (!sclk_o && !sdata_o && trial_code == '0 && !busy));
endmodule

bind sar_readout_seq sar_readout_chk #(.W(W), .HALF(HALF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_o     (sclk_o),
  .sdata_o    (sdata_o),
  .trial_code (trial_code),
  .busy       (busy),
  .start      (start)
);

// File: tb/tb_sar_readout_seq.sv
`timescale 1ns/1ps
module tb_sar_readout_seq;
  localparam int W        = 8;
  localparam int HALF     = 6;
  localparam int WAKE_CYC = 98;
  localparam int LOAD_AT  = WAKE_CYC - HALF;
  localparam int END_AT   = WAKE_CYC + (2 * W - 1) * HALF;
  localparam int BUDGET   = 196;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_en = 1'b0;
  logic cmp_ge;
  logic [W-1:0] trial_code;
  logic sclk_o, sdata_o;
  int vin_mv = 0;
  int ntests = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // Ideal comparator over a 0.5 V .. 2.5 V span, 256 steps.
  assign cmp_ge = ((vin_mv - 500) * 256) >= (int'(trial_code) * 2000);

  sar_readout_seq #(.W(W), .HALF(HALF), .WAKE_CYC(WAKE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .cmp_ge(cmp_ge),
    .trial_code(trial_code), .sclk_o(sclk_o), .sdata_o(sdata_o));

  function automatic int exp_code(int mv);
    int v;
    if (mv <= 500) return 0;
    v = (mv - 500) * 256 / 2000;
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_hold(int cycles, string tag);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (sclk_o || sdata_o || trial_code != '0) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  // Full conversion; en held high except for [glo, ghi), dropped at drop_at.
  task automatic conv_run(int mv, int drop_at, int glo, int ghi, string tag);
    int wave_err = 0, first_rise = -1, last_fall = -1, bits = 0;
    int code = 0, exp = exp_code(mv), wake_err = 0;
    bit prev = 1'b0, es, ed;
    vin_mv = mv;
    @(negedge clk); conv_en = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= 200; n++) begin
      @(posedge clk); #1;
      if (n == glo) conv_en = 1'b0;
      if (n == ghi) conv_en = 1'b1;
      if (n == drop_at) conv_en = 1'b0;
      es = (n >= WAKE_CYC) && (n < END_AT) && (((n - WAKE_CYC) / HALF) % 2 == 0);
      ed = 1'b0;
      if (n >= LOAD_AT && n < END_AT) ed = exp[W-1-((n - LOAD_AT) / (2 * HALF))];
      if (sclk_o !== es || sdata_o !== ed) wave_err++;
      if (n < WAKE_CYC - 2 * W - HALF - 1 && trial_code != '0) wake_err++;
      if (n >= END_AT && trial_code != '0) wake_err++;
      if (sclk_o && !prev) begin
        code = (code << 1) | int'(sdata_o);
        bits++;
        if (first_rise < 0) first_rise = n;
      end
      if (!sclk_o && prev) last_fall = n;
      prev = sclk_o;
    end
    check(wave_err == 0, {tag, " R5 waveform"}, wave_err, 0);
    check(code == exp && bits == W, {tag, " R4 R7 code"}, code, exp);
    check(first_rise == WAKE_CYC, {tag, " R6 first rise"}, first_rise, WAKE_CYC);
    check(last_fall == END_AT && last_fall <= BUDGET, {tag, " R6 end"}, last_fall, END_AT);
    check(wake_err == 0, {tag, " R1 trial idle"}, wake_err, 0);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    check(!sclk_o && !sdata_o && trial_code == '0, "R1 reset outputs", int'(sclk_o), 0);
    idle_hold(20, "R1 idle after reset");
  endtask

  task automatic test_codes();
    conv_run(1500, 20, 0, 0, "mid");
    conv_run(1234, 20, 0, 0, "arb");
    conv_run(2500, 20, 0, 0, "R7 fullscale");
    conv_run(3000, 20, 0, 0, "R7 over");
    conv_run(500, 20, 0, 0, "R7 zero");
    conv_run(300, 20, 0, 0, "R7 under");
    idle_hold(10, "R1 between");
  endtask

  task automatic test_retrigger();
    conv_run(1800, 999, 40, 60, "R3 glitch");
    idle_hold(80, "R3 held enable no restart");
    @(negedge clk); conv_en = 1'b0;
    repeat (3) @(posedge clk);
    conv_run(900, 20, 0, 0, "R3 rearm");
  endtask

  task automatic test_reset_mid();
    vin_mv = 2000;
    @(negedge clk); conv_en = 1'b1;
    repeat (120) @(posedge clk);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check(!sclk_o && !sdata_o && trial_code == '0, "R8 mid reset", int'(trial_code), 0);
    @(negedge clk); rst_n = 1'b1;
    idle_hold(150, "R2 enable high through reset");
    @(negedge clk); conv_en = 1'b0;
    repeat (2) @(posedge clk);
    conv_run(2100, 20, 0, 0, "R2 after reset");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    test_reset_state();
    test_codes();
    test_retrigger();
    test_reset_mid();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      ntests++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule